// File: doc/BRIEF.md
# Half-Wave Overcurrent and Fault Supervisor

This block guards the power switch of a mains-synchronised load controller. Analog comparators outside the block supply one bit for a hard overcurrent threshold and one for a lower, sustained overcurrent threshold. The block also receives a strobe once per mains half-wave, a one-millisecond tick, an overtemperature flag and three supply-level flags. From these it drives three outputs. The first is an immediate hard-off request for the power switch. The second is an enable for the output stage. The third is a global reset that holds the other blocks of the controller while the supply is not trustworthy.

A hard overcurrent trips at once and stays tripped until the next global reset. A sustained overcurrent is handled more gently, so that the switch is never cut in the middle of a half-wave. A saturating accumulator adds one for each millisecond tick on which the lower threshold is exceeded. It removes one for every few ticks on which it is not. When the accumulator reaches the trip time, the stage is held off for the whole of the half-wave that follows. Overtemperature disables the stage until a supply power cycle. In the phase-control modes, a brief supply sag below an intermediate level disables only the output stage, and the stage stays off until the next half-wave begins.

Top module: `halfwave_fault_sup`

## Requirements
- R1: After `rst`, `glob_rst` is 1 and `stage_en` and `hard_off` are 0. `glob_rst` stays 1 until `sup_on_ok` is seen high, and it falls one cycle later.
- R2: While `glob_rst` is 0, a low `sup_rst_ok` sets `glob_rst` on the next cycle. `hard_off` then clears one cycle after `glob_rst` rises.
- R3: A high `oc_fast` sets `hard_off` on the next clock. `stage_en` is 0 from the cycle after that.
- R4: `hard_off` holds through any number of half-wave strobes and is cleared only by `glob_rst`.
- R5: When the slow accumulator reaches TRIP_MS (default 120) ticks, the current half-wave is left untouched. `stage_en` is 0 from the next `zc_strobe` until the one after it. Then the accumulator restarts from zero.
- R6: Each `ms_tick` with `oc_slow` high adds 1. Every DECAY_DIV-th (default 4) `ms_tick` with `oc_slow` low removes 1, and the accumulator does not go below 0. An alternating on/off tick pattern therefore needs 159 on-ticks to trip, not 120.
- R7: A high `over_temp` forces `stage_en` to 0 until `glob_rst` has been asserted. Half-wave strobes do not release it.
- R8: With `phase_mode` = 1, a low `sup_mid_ok` forces `stage_en` to 0 while `glob_rst` stays 0. The stage returns only after a `zc_strobe` seen while `sup_mid_ok` is high.
- R9: With `phase_mode` = 0, `sup_mid_ok` has no effect on `stage_en`.
- R10: With no fault active and `glob_rst` at 0, `stage_en` is 1, two cycles after the last fault cause clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_fast | input | 1 | Hard overcurrent comparator |
| oc_slow | input | 1 | Sustained overcurrent comparator |
| zc_strobe | input | 1 | One-cycle pulse at each half-wave start |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| over_temp | input | 1 | Die overtemperature flag |
| sup_on_ok | input | 1 | Supply above power-up level |
| sup_rst_ok | input | 1 | Supply above reset level |
| sup_mid_ok | input | 1 | Supply above output-stage level |
| phase_mode | input | 1 | 1 in the phase-control operating modes |
| hard_off | output | 1 | Immediate switch-off request |
| stage_en | output | 1 | Output stage enable |
| glob_rst | output | 1 | Global reset for sibling blocks |

## Verification
The hardest state to reach is the accumulator trip under intermittent overcurrent. It appears only after a long, exact interleaving of on and off ticks, and a decrement that wraps below zero would hide inside that same sequence. The stimulus first applies forty off-ticks to an empty accumulator. It then checks that exactly 120 on-ticks are still needed to trip. Next it drives 158 alternating on/off pairs, confirms that the following half-wave is still enabled, and shows that one more on-tick blocks the half-wave after that.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef struct packed {
    logic fast;
    logic temp;
    logic dip;
  } hfs_fault_t;

  localparam int unsigned HFS_TRIP_MS_DEF   = 120;
  localparam int unsigned HFS_DECAY_DIV_DEF = 4;
endpackage

// File: rtl/hfs_supply_mon.sv
module hfs_supply_mon (
  input  logic clk,
  input  logic rst,
  input  logic sup_on_ok,
  input  logic sup_rst_ok,
  output logic glob_rst
);
  always_ff @(posedge clk) begin
    if (rst)                       glob_rst <= 1'b1;
    else if (glob_rst && sup_on_ok) glob_rst <= 1'b0;
    else if (!glob_rst && !sup_rst_ok) glob_rst <= 1'b1;
  end

  // R1: reset held until power-up level seen
  a_r1_hold_until_on: assert property (@(posedge clk) disable iff (rst)
    (glob_rst && !sup_on_ok) |=> glob_rst);
  // R2: brown-out reasserts reset
  a_r2_brownout: assert property (@(posedge clk) disable iff (rst)
    (!glob_rst && !sup_rst_ok) |=> glob_rst);
endmodule

// File: rtl/hfs_slow_integ.sv
module hfs_slow_integ #(
  parameter int unsigned TRIP_MS   = hfs_pkg::HFS_TRIP_MS_DEF,
  parameter int unsigned DECAY_DIV = hfs_pkg::HFS_DECAY_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic zc_strobe,
  input  logic ms_tick,
  input  logic oc_slow,
  output logic blk
);
  localparam int unsigned ACC_W = $clog2(TRIP_MS + 1);
  localparam int unsigned DC_W  = (DECAY_DIV > 1) ? $clog2(DECAY_DIV) : 1;
  localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(TRIP_MS - 1);
  localparam logic [DC_W-1:0]  DC_TOP  = DC_W'(DECAY_DIV - 1);

  logic [ACC_W-1:0] acc;
  logic [DC_W-1:0]  dcnt;
  logic             pend;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      dcnt <= '0;
      pend <= 1'b0;
      blk  <= 1'b0;
    end else begin
      if (zc_strobe) begin
        blk  <= pend;
        pend <= 1'b0;
      end
      if (ms_tick && !pend) begin
        if (oc_slow) begin
          if (acc == ACC_TOP) begin
            acc  <= '0;
            dcnt <= '0;
            pend <= 1'b1;
          end else begin
            acc <= acc + 1'b1;
          end
        end else begin
          if (dcnt == DC_TOP) begin
            dcnt <= '0;
            if (acc != '0) acc <= acc - 1'b1;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
      end
    end
  end

  // R6: accumulator never passes the trip value
  a_r6_acc_bound: assert property (@(posedge clk) disable iff (rst)
    acc <= ACC_TOP);
  // R6: no wrap below zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (acc == '0 && ms_tick && !oc_slow && !pend && !clr) |=> acc == '0);
  // R5: pending trip blocks the following half-wave
  a_r5_pend_to_blk: assert property (@(posedge clk) disable iff (rst)
    (pend && zc_strobe && !clr) |=> blk);
endmodule

// File: rtl/hfs_stage_gate.sv
module hfs_stage_gate (
  input  logic clk,
  input  logic rst,
  input  logic glob_rst,
  input  logic oc_fast,
  input  logic over_temp,
  input  logic phase_mode,
  input  logic sup_mid_ok,
  input  logic zc_strobe,
  input  logic blk,
  output logic hard_off,
  output logic stage_en
);
  import hfs_pkg::*;

  hfs_fault_t f_q;

  always_ff @(posedge clk) begin
    if (rst || glob_rst) begin
      f_q      <= '0;
      stage_en <= 1'b0;
    end else begin
      f_q.fast <= f_q.fast | oc_fast;
      f_q.temp <= f_q.temp | over_temp;
      if (phase_mode && !sup_mid_ok) f_q.dip <= 1'b1;
      else if (zc_strobe)            f_q.dip <= 1'b0;
      stage_en <= !(f_q.fast || f_q.temp || f_q.dip || blk);
    end
  end

  assign hard_off = f_q.fast;

  // R4: hard-off sticky until global reset
  a_r4_fast_hold: assert property (@(posedge clk) disable iff (rst)
    (hard_off && !glob_rst) |=> hard_off);
  // R3: hard-off removes the stage enable
  a_r3_fast_off: assert property (@(posedge clk) disable iff (rst)
    hard_off |=> !stage_en);
  // R7: overtemperature sticky until global reset
  a_r7_temp_hold: assert property (@(posedge clk) disable iff (rst)
    (f_q.temp && !glob_rst) |=> f_q.temp);
  // R8: supply dip keeps the stage off
  a_r8_dip_off: assert property (@(posedge clk) disable iff (rst)
    f_q.dip |=> !stage_en);
  // R5: blocked half-wave keeps the stage off
  a_r5_blk_off: assert property (@(posedge clk) disable iff (rst)
    blk |=> !stage_en);
  // R1: global reset keeps the stage off
  a_r1_rst_off: assert property (@(posedge clk) disable iff (rst)
    glob_rst |=> !stage_en);
endmodule

// File: rtl/halfwave_fault_sup.sv
module halfwave_fault_sup #(
  parameter int unsigned TRIP_MS   = hfs_pkg::HFS_TRIP_MS_DEF,
  parameter int unsigned DECAY_DIV = hfs_pkg::HFS_DECAY_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_fast,
  input  logic oc_slow,
  input  logic zc_strobe,
  input  logic ms_tick,
  input  logic over_temp,
  input  logic sup_on_ok,
  input  logic sup_rst_ok,
  input  logic sup_mid_ok,
  input  logic phase_mode,
  output logic hard_off,
  output logic stage_en,
  output logic glob_rst
);
  logic blk;
  logic integ_clr;

  hfs_supply_mon u_sup (
    .clk        (clk),
    .rst        (rst),
    .sup_on_ok  (sup_on_ok),
    .sup_rst_ok (sup_rst_ok),
    .glob_rst   (glob_rst)
  );

  assign integ_clr = glob_rst | hard_off;

  hfs_slow_integ #(.TRIP_MS(TRIP_MS), .DECAY_DIV(DECAY_DIV)) u_integ (
    .clk       (clk),
    .rst       (rst),
    .clr       (integ_clr),
    .zc_strobe (zc_strobe),
    .ms_tick   (ms_tick),
    .oc_slow   (oc_slow),
    .blk       (blk)
  );

  hfs_stage_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .glob_rst   (glob_rst),
    .oc_fast    (oc_fast),
    .over_temp  (over_temp),
    .phase_mode (phase_mode),
    .sup_mid_ok (sup_mid_ok),
    .zc_strobe  (zc_strobe),
    .blk        (blk),
    .hard_off   (hard_off),
    .stage_en   (stage_en)
  );
endmodule

// File: tb/test_halfwave_fault_sup.sv
module test_halfwave_fault_sup;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oc_fast = 0, oc_slow = 0, zc_strobe = 0, ms_tick = 0, over_temp = 0;
  logic sup_on_ok = 0, sup_rst_ok = 0, sup_mid_ok = 0, phase_mode = 0;
  logic hard_off, stage_en, glob_rst;

  always #5 clk = ~clk;

  halfwave_fault_sup i_halfwave_fault_sup (
    .clk(clk), .rst(rst), .oc_fast(oc_fast), .oc_slow(oc_slow),
    .zc_strobe(zc_strobe), .ms_tick(ms_tick), .over_temp(over_temp),
    .sup_on_ok(sup_on_ok), .sup_rst_ok(sup_rst_ok), .sup_mid_ok(sup_mid_ok),
    .phase_mode(phase_mode), .hard_off(hard_off), .stage_en(stage_en),
    .glob_rst(glob_rst)
  );

  typedef struct {
    logic [2:0] v;   // {hard_off, stage_en, glob_rst}
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_total++;
        if ({hard_off, stage_en, glob_rst} !== e.v) begin
          n_fail++;
          $display("FAIL %s: {hard_off,stage_en,glob_rst} actual=%b expected=%b",
                   e.tag, {hard_off, stage_en, glob_rst}, e.v);
        end
      end
    end
  end

  task automatic expect_out(input int n, input logic h, input logic s,
                            input logic g, input string tag);
    exp_t e;
    repeat (n) @(posedge clk);
    #1;
    e.v = {h, s, g};
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ms(input logic slow);
    @(negedge clk);
    oc_slow = slow;
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic zc();
    @(negedge clk);
    zc_strobe = 1'b1;
    @(negedge clk);
    zc_strobe = 1'b0;
  endtask

  task automatic power_cycle(input string tag);
    @(negedge clk);
    sup_on_ok = 0; sup_rst_ok = 0; sup_mid_ok = 0;
    expect_out(2, 0, 0, 1, tag);
    sup_on_ok = 1; sup_rst_ok = 1; sup_mid_ok = 1;
    expect_out(3, 0, 1, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_out(1, 0, 0, 1, "R1 reset state");
    sup_rst_ok = 1; sup_mid_ok = 1;
    expect_out(3, 0, 0, 1, "R1 held below power-up level");
    sup_on_ok = 1;
    expect_out(1, 0, 0, 0, "R1 release one cycle later");
    expect_out(1, 0, 1, 0, "R10 stage enabled");

    // R6 saturation at zero, then R5 exact trip
    for (int i = 0; i < 40; i++) ms(0);
    for (int i = 0; i < 119; i++) ms(1);
    zc();
    expect_out(2, 0, 1, 0, "R6 no trip after 119 on-ticks");
    ms(1);
    expect_out(2, 0, 1, 0, "R5 current half-wave untouched");
    zc();
    expect_out(2, 0, 0, 0, "R5 next half-wave blocked");
    zc();
    expect_out(2, 0, 1, 0, "R5 block lasts one half-wave");

    // R6 intermittent overcurrent trips later
    for (int i = 0; i < 158; i++) begin
      ms(1);
      ms(0);
    end
    zc();
    expect_out(2, 0, 1, 0, "R6 158 pairs not yet tripped");
    ms(1);
    zc();
    expect_out(2, 0, 0, 0, "R6 trip on 159th on-tick");
    ms(0);
    zc();
    expect_out(2, 0, 1, 0, "R6 stage back after block");

    // R3/R4 hard overcurrent
    @(negedge clk);
    oc_fast = 1;
    expect_out(1, 1, 1, 0, "R3 hard_off next clock");
    oc_fast = 0;
    expect_out(1, 1, 0, 0, "R3 stage_en drops");
    zc();
    zc();
    expect_out(2, 1, 0, 0, "R4 sticky across half-waves");
    @(negedge clk);
    sup_on_ok = 0; sup_rst_ok = 0;
    expect_out(1, 1, 0, 1, "R2 brown-out asserts glob_rst");
    expect_out(1, 0, 0, 1, "R4 cleared by glob_rst");
    sup_on_ok = 1; sup_rst_ok = 1;
    expect_out(1, 0, 0, 0, "R1 release after brown-out");
    expect_out(1, 0, 1, 0, "R10 stage back after brown-out");

    // R7 overtemperature
    @(negedge clk);
    over_temp = 1;
    @(negedge clk);
    over_temp = 0;
    expect_out(2, 0, 0, 0, "R7 overtemp disables stage");
    zc();
    zc();
    expect_out(2, 0, 0, 0, "R7 not released by half-waves");
    power_cycle("R7 released by power cycle");

    // R8 supply dip in phase mode
    @(negedge clk);
    phase_mode = 1; sup_mid_ok = 0;
    expect_out(3, 0, 0, 0, "R8 dip disables stage only");
    sup_mid_ok = 1;
    expect_out(3, 0, 0, 0, "R8 stays off in same half-wave");
    zc();
    expect_out(2, 0, 1, 0, "R8 back on next half-wave");

    // R9 dip ignored outside phase mode
    @(negedge clk);
    phase_mode = 0; sup_mid_ok = 0;
    expect_out(3, 0, 1, 0, "R9 dip ignored");
    sup_mid_ok = 1;
    expect_out(2, 0, 1, 0, "R9 still enabled");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule